// File: doc/BRIEF.md
# Phase-Frequency Comparator with Lock Indicator

This block compares a reference strobe against a feedback strobe. Each strobe is one clock wide, and both come from divider chains clocked by the same oscillator clock that runs this block. Phase error is counted in whole periods of that clock. The block gives out pump-up and pump-down enables and a drive-valid flag. A low drive-valid flag means the pump pin floats. The block also gives a lock indicator and a monitor output that can show either the lock state or the raw strobe timing.

When the strobes arrive in the same cycle, the block still issues a one-cycle up-and-down pulse. The pump stays undriven on that pulse, and there is no dead zone around zero error. A sense input swaps the up and down roles to match the slope of the VCO and loop filter.

Lock falls as soon as a pending error reaches the drop threshold. Lock rises only after a run of consecutive small-error comparisons. A float control input forces the pump to float. A run input puts the block into power save, and the block starts cleanly when it leaves power save.

Top module: `phase_lock_cmp`

## Requirements
- R1: After reset, with no strobes given, `pump_up`, `pump_dn`, `pump_oe` and `lock_out` are all low.
- R2: With `lead_up`=1, a reference strobe in cycle t followed by a feedback strobe in cycle t+k raises `pump_up` with `pump_oe` high in cycles t+1 through t+k, and `pump_dn` stays low.
- R3: With `lead_up`=1, a feedback strobe in cycle t followed by a reference strobe in cycle t+k raises `pump_dn` with `pump_oe` high in cycles t+1 through t+k.
- R4: Two strobes in the same cycle give exactly one following cycle in which `pump_up` and `pump_dn` are both high and `pump_oe` is low.
- R5: With `lead_up`=0, the roles of `pump_up` and `pump_dn` in R2 and R3 are exchanged.
- R6: When `drv_allow` is low, `pump_oe` is low, and the up/down enables are not affected.
- R7: When a comparison has been pending for 3 cycles (UP_TH), `lock_out` goes low on the next cycle.
- R8: A comparison whose error is 2 cycles or less (LO_TH) counts as good. `lock_out` rises in the cycle after the third consecutive good comparison (GOOD_N). Any comparison that reaches UP_TH restarts the count.
- R9: `mon_out` follows `lock_out` when `mon_timing`=0. When `mon_timing`=1 it follows the reference strobe input if `lead_up`=1, and the feedback strobe input if `lead_up`=0.
- R10: While `run_en` is low, `pump_up`, `pump_dn` and `pump_oe` are low and `lock_out` is high. Strobes given in this time leave no pending comparison behind, and the internal lock state is cleared.
- R11: After `run_en` returns high, `pump_up` and `pump_dn` stay low until the first complete strobe pair has closed. From the cycle after that pair they follow R2 to R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | Reference strobe, one cycle wide |
| fb_pulse | input | 1 | Feedback strobe, one cycle wide |
| run_en | input | 1 | High for normal operation, low for power save |
| drv_allow | input | 1 | Low forces the pump output to float |
| lead_up | input | 1 | Polarity: 1 maps reference-leading to pump up |
| mon_timing | input | 1 | Monitor select: 0 lock, 1 strobe timing |
| pump_up | output | 1 | Pump-up enable |
| pump_dn | output | 1 | Pump-down enable |
| pump_oe | output | 1 | High when the pump pin is actively driven |
| lock_out | output | 1 | Lock indicator |
| mon_out | output | 1 | Monitor output |

## Verification
The bench builds the block with its default parameters: a 4-bit error counter, a drop threshold of 3, a good threshold of 2 and a run length of 3. These small values let short sequences of 1-, 2-, 3- and 4-cycle errors reach both sides of both thresholds. They also let the bench break a good run partway and build it up again. Counter saturation at 15 needs a much longer stall than any sequence the bench drives, so only the threshold crossings are exercised.

// File: rtl/plc_pkg.sv
package plc_pkg;
  typedef enum logic [1:0] {
    PD_IDLE = 2'd0,
    PD_LEAD = 2'd1,
    PD_LAG  = 2'd2
  } pd_state_e;
endpackage

// File: rtl/plc_rst_sync.sv
module plc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/plc_tracker.sv
// Tracks which strobe arrived first and counts cycles until the other one.
module plc_tracker
  import plc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             fr,
  input  logic             fp,
  output logic             lead_o,
  output logic             lag_o,
  output logic             coin_o,
  output logic             pend_o,
  output logic             close_o,
  output logic [CNT_W-1:0] err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  pd_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             coin_q, coin_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    coin_d  = 1'b0;
    close_o = 1'b0;
    if (!run) begin
      st_d   = PD_IDLE;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else begin
      unique case (st_q)
        PD_IDLE: begin
          if (fr && fp) begin
            coin_d  = 1'b1;
            close_o = 1'b1;
          end else if (fr) begin
            st_d   = PD_LEAD;
            cnt_d  = CNT_ONE;
            cnt_en = 1'b1;
          end else if (fp) begin
            st_d   = PD_LAG;
            cnt_d  = CNT_ONE;
            cnt_en = 1'b1;
          end
        end
        PD_LEAD: begin
          if (fp) begin
            st_d    = PD_IDLE;
            close_o = 1'b1;
          end else begin
            cnt_d  = cnt_q + CNT_ONE;
            cnt_en = (cnt_q != CNT_MAX);
          end
        end
        PD_LAG: begin
          if (fr) begin
            st_d    = PD_IDLE;
            close_o = 1'b1;
          end else begin
            cnt_d  = cnt_q + CNT_ONE;
            cnt_en = (cnt_q != CNT_MAX);
          end
        end
        default: st_d = PD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PD_IDLE;
      cnt_q  <= '0;
      coin_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      coin_q <= coin_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign lead_o = (st_q == PD_LEAD);
  assign lag_o  = (st_q == PD_LAG);
  assign coin_o = coin_q;
  assign pend_o = (st_q != PD_IDLE);
  assign err_o  = pend_o ? cnt_q : '0;
endmodule

// File: rtl/plc_lockdet.sv
// Lock indicator: fast drop on a large error, slow rise after a good run.
module plc_lockdet #(
  parameter int CNT_W  = 4,
  parameter int UP_TH  = 3,
  parameter int LO_TH  = 2,
  parameter int GOOD_N = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pend,
  input  logic             close,
  input  logic [CNT_W-1:0] err,
  output logic             locked_o
);
  localparam int               GOOD_W   = $clog2(GOOD_N + 1);
  localparam logic [GOOD_W-1:0] GOOD_TOP = GOOD_W'(GOOD_N);
  localparam logic [GOOD_W-1:0] GOOD_PRE = GOOD_W'(GOOD_N - 1);

  logic [GOOD_W-1:0] good_q, good_d;
  logic              locked_q, locked_d;
  logic              bad, good;

  assign bad  = pend && (err >= CNT_W'(UP_TH));
  assign good = close && (err <= CNT_W'(LO_TH));

  always_comb begin
    good_d   = good_q;
    locked_d = locked_q;
    if (!run || bad) begin
      good_d   = '0;
      locked_d = 1'b0;
    end else if (good) begin
      if (good_q != GOOD_TOP) good_d = good_q + GOOD_W'(1);
      if (good_q >= GOOD_PRE) locked_d = 1'b1;
    end else if (close) begin
      good_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      good_q   <= good_d;
      locked_q <= locked_d;
    end
  end

  assign locked_o = locked_q;
endmodule

// File: rtl/plc_drive.sv
// Output stage: polarity, arming after wake, float control, monitor select.
module plc_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic allow,
  input  logic sense,
  input  logic mon_sel,
  input  logic fr,
  input  logic fp,
  input  logic lead,
  input  logic lag,
  input  logic coin,
  input  logic close,
  input  logic locked,
  output logic up_o,
  output logic dn_o,
  output logic oe_o,
  output logic lock_o,
  output logic mon_o
);
  logic armed_q, armed_d;
  logic gate, ahead, behind;

  always_comb begin
    armed_d = armed_q;
    if (!run)       armed_d = 1'b0;
    else if (close) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign gate   = run && armed_q;
  assign ahead  = lead || coin;
  assign behind = lag || coin;
  assign up_o   = gate && (sense ? ahead : behind);
  assign dn_o   = gate && (sense ? behind : ahead);
  assign oe_o   = allow && (up_o ^ dn_o);
  assign lock_o = locked || !run;
  assign mon_o  = mon_sel ? (sense ? fr : fp) : lock_o;
endmodule

// File: rtl/phase_lock_cmp.sv
module phase_lock_cmp #(
  parameter int CNT_W  = 4,
  parameter int UP_TH  = 3,
  parameter int LO_TH  = 2,
  parameter int GOOD_N = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_pulse,
  input  logic fb_pulse,
  input  logic run_en,
  input  logic drv_allow,
  input  logic lead_up,
  input  logic mon_timing,
  output logic pump_up,
  output logic pump_dn,
  output logic pump_oe,
  output logic lock_out,
  output logic mon_out
);
  logic             rst_i_n;
  logic             trk_lead, trk_lag, trk_coin, trk_pend, trk_close;
  logic [CNT_W-1:0] trk_err;
  logic             det_locked;

  plc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  plc_tracker #(.CNT_W(CNT_W)) u_trk (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .run     (run_en),
    .fr      (ref_pulse),
    .fp      (fb_pulse),
    .lead_o  (trk_lead),
    .lag_o   (trk_lag),
    .coin_o  (trk_coin),
    .pend_o  (trk_pend),
    .close_o (trk_close),
    .err_o   (trk_err)
  );

  plc_lockdet #(
    .CNT_W(CNT_W), .UP_TH(UP_TH), .LO_TH(LO_TH), .GOOD_N(GOOD_N)
  ) u_det (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .run      (run_en),
    .pend     (trk_pend),
    .close    (trk_close),
    .err      (trk_err),
    .locked_o (det_locked)
  );

  plc_drive u_drv (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .run     (run_en),
    .allow   (drv_allow),
    .sense   (lead_up),
    .mon_sel (mon_timing),
    .fr      (ref_pulse),
    .fp      (fb_pulse),
    .lead    (trk_lead),
    .lag     (trk_lag),
    .coin    (trk_coin),
    .close   (trk_close),
    .locked  (det_locked),
    .up_o    (pump_up),
    .dn_o    (pump_dn),
    .oe_o    (pump_oe),
    .lock_o  (lock_out),
    .mon_o   (mon_out)
  );
endmodule

// File: rtl/plc_checker.sv
module plc_checker #(
  parameter int CNT_W = 4,
  parameter int UP_TH = 3,
  parameter int LO_TH = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             allow,
  input logic             up,
  input logic             dn,
  input logic             oe,
  input logic             lock,
  input logic             pend,
  input logic             close,
  input logic [CNT_W-1:0] err,
  input logic             locked_q
);
  a_r6_float_forced: assert property (@(posedge clk) disable iff (!rst_n)
    !allow |-> !oe);

  a_r7_drop_on_large_error: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pend && (err >= CNT_W'(UP_TH))) |=> !locked_q);

  a_r8_rise_after_good: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(run && close && (err <= CNT_W'(LO_TH))));

  a_r10_save_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!up && !dn && !oe && lock));

  a_r11_wake_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (!up && !dn));
endmodule

bind phase_lock_cmp plc_checker #(
  .CNT_W(CNT_W), .UP_TH(UP_TH), .LO_TH(LO_TH)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run_en),
  .allow    (drv_allow),
  .up       (pump_up),
  .dn       (pump_dn),
  .oe       (pump_oe),
  .lock     (lock_out),
  .pend     (trk_pend),
  .close    (trk_close),
  .err      (trk_err),
  .locked_q (det_locked)
);

// File: tb/test_phase_lock_cmp.sv
`timescale 1ns/1ps
module test_phase_lock_cmp;
  logic clk, rst_n;
  logic ref_pulse, fb_pulse, run_en, drv_allow, lead_up, mon_timing;
  logic pump_up, pump_dn, pump_oe, lock_out, mon_out;
  logic cfg_run, cfg_allow, cfg_sense, cfg_mon;

  int n_cmp  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [9:0] q_me[$];
  string      q_tag[$];

  phase_lock_cmp i_phase_lock_cmp (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .run_en(run_en), .drv_allow(drv_allow), .lead_up(lead_up),
    .mon_timing(mon_timing), .pump_up(pump_up), .pump_dn(pump_dn),
    .pump_oe(pump_oe), .lock_out(lock_out), .mon_out(mon_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // expected bits: {up, dn, oe, lock, mon}
  task automatic step(input logic fr, input logic fp, input logic [4:0] exp, input string tag);
    @(negedge clk);
    ref_pulse  = fr;
    fb_pulse   = fp;
    run_en     = cfg_run;
    drv_allow  = cfg_allow;
    lead_up    = cfg_sense;
    mon_timing = cfg_mon;
    q_me.push_back({5'b11111, exp});
    q_tag.push_back(tag);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      if (q_me.size() > 0) begin
        logic [9:0] me;
        logic [4:0] act;
        string      tg;
        me  = q_me.pop_front();
        tg  = q_tag.pop_front();
        act = {pump_up, pump_dn, pump_oe, lock_out, mon_out};
        n_cmp++;
        if (((act ^ me[4:0]) & me[9:5]) != 5'b0) begin
          n_fail++;
          $display("FAIL %s: got %b expected %b", tg, act, me[4:0]);
        end
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ref_pulse = 1'b0; fb_pulse = 1'b0;
    run_en = 1'b1; drv_allow = 1'b1; lead_up = 1'b1; mon_timing = 1'b0;
    cfg_run = 1'b1; cfg_allow = 1'b1; cfg_sense = 1'b1; cfg_mon = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R4 coincident pulses, R8 lock after three good pairs
    step(1, 1, 5'b00000, "R1 idle after reset");
    step(0, 0, 5'b11000, "R4 coincident up+dn, float");
    step(1, 1, 5'b00000, "R4 pulse lasts one cycle");
    step(0, 0, 5'b11000, "R4 second coincident");
    step(1, 1, 5'b00000, "R8 no lock after two good");
    step(0, 0, 5'b11011, "R8 lock after third good");

    // R2 reference leads by 2
    step(1, 0, 5'b00011, "R2 before lead");
    step(0, 0, 5'b10111, "R2 up driven");
    step(0, 1, 5'b10111, "R2 up through closing cycle");
    step(0, 0, 5'b00011, "R2 up released");

    // R3 feedback leads by 2
    step(0, 1, 5'b00011, "R3 before lag");
    step(0, 0, 5'b01111, "R3 dn driven");
    step(1, 0, 5'b01111, "R3 dn through closing cycle");
    step(0, 0, 5'b00011, "R3 dn released");

    // R5 inverted polarity
    cfg_sense = 1'b0;
    step(1, 0, 5'b00011, "R5 idle");
    step(0, 1, 5'b01111, "R5 reference lead maps to dn");
    step(0, 0, 5'b00011, "R5 released");
    cfg_sense = 1'b1;

    // R6 forced float
    cfg_allow = 1'b0;
    step(1, 0, 5'b00011, "R6 idle");
    step(0, 0, 5'b10011, "R6 up kept, oe low");
    step(0, 1, 5'b10011, "R6 still floating");
    cfg_allow = 1'b1;
    step(0, 0, 5'b00011, "R6 released");

    // R7 lock drop at three pending cycles
    step(1, 0, 5'b00011, "R7 idle");
    step(0, 0, 5'b10111, "R7 pending 1");
    step(0, 0, 5'b10111, "R7 pending 2");
    step(0, 0, 5'b10111, "R7 pending 3 lock still up");
    step(0, 1, 5'b10100, "R7 lock dropped");
    step(0, 0, 5'b00000, "R7 idle unlocked");

    // R8 good run broken by a large error, then rebuilt
    step(1, 0, 5'b00000, "R8 run A1");
    step(0, 1, 5'b10100, "R8 run A1 close");
    step(1, 0, 5'b00000, "R8 run A2");
    step(0, 1, 5'b10100, "R8 run A2 close");
    step(0, 1, 5'b00000, "R8 two good no lock");
    step(0, 0, 5'b01100, "R8 bad pair 1");
    step(0, 0, 5'b01100, "R8 bad pair 2");
    step(1, 0, 5'b01100, "R8 bad pair 3");
    step(1, 0, 5'b00000, "R8 run B1");
    step(0, 1, 5'b10100, "R8 run B1 close");
    step(1, 0, 5'b00000, "R8 run B2");
    step(0, 1, 5'b10100, "R8 run B2 close");
    step(1, 0, 5'b00000, "R8 count restarted, no lock");
    step(0, 1, 5'b10100, "R8 run B3 close");
    step(0, 0, 5'b00011, "R8 relocked");

    // R9 monitor selection
    cfg_mon = 1'b1;
    step(1, 0, 5'b00011, "R9 mon shows reference");
    step(0, 1, 5'b10110, "R9 feedback not shown");
    cfg_sense = 1'b0;
    step(1, 0, 5'b00010, "R9 reference not shown");
    step(0, 1, 5'b01111, "R9 mon shows feedback");
    step(0, 0, 5'b00010, "R9 mon low");
    cfg_mon = 1'b0; cfg_sense = 1'b1;

    // R10 power save, R11 wake suppression
    cfg_run = 1'b0;
    step(1, 0, 5'b00011, "R10 save, lock high");
    step(0, 0, 5'b00011, "R10 strobe ignored");
    step(0, 1, 5'b00011, "R10 strobe ignored 2");
    cfg_run = 1'b1;
    step(1, 0, 5'b00000, "R10 lock state cleared");
    step(0, 0, 5'b00000, "R11 pending but suppressed");
    step(0, 1, 5'b00000, "R11 first pair closing");
    step(0, 0, 5'b00000, "R11 idle after arming");
    step(1, 0, 5'b00000, "R11 second pair start");
    step(0, 0, 5'b10100, "R11 up after arming");
    step(0, 1, 5'b10100, "R11 closing");
    step(0, 0, 5'b00000, "R11 released");

    @(negedge clk);
    #2;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end
endmodule